// File: doc/BRIEF.md
# Multicycle Integer RISC Datapath

This block executes a small 32-bit load/store integer instruction set, one instruction at a time, without pipelining. Every instruction walks through up to five steps. Fetch reads the instruction word and forms the sequential successor address. Decode latches the word and reads both source registers. Execute runs the ALU and either computes an address or resolves a branch condition. The memory step accesses data memory and commits the next program counter. Write-back updates the register file. Stores, branches and unsupported encodings finish after the memory step. Register-to-register operations, immediate operations and loads also use the write-back step.

The core drives two memory ports, one for instructions and one for data. Both are synchronous and have a fixed latency of one cycle: an address presented in one cycle returns its read data in the next. Neither port carries a handshake, because the access time is fixed and the core never stalls. A step indicator and a retire strobe are exported so that an observer can follow execution.

Top module: `mc_risc_core`

## Requirements
- R1: While reset is low and in the first cycle after it, the step indicator reads 0 (fetch), the instruction address equals the RESET_PC parameter, and no data write or retire is signalled.
- R2: The step indicator runs fetch(0) → decode(1) → execute(2) → memory(3), then either write-back(4) or fetch. The instruction-memory enable is high only in fetch, with the address equal to the current program counter.
- R3: Instruction word fields, numbered with bit 31 as the most significant bit: opcode [31:26], rs1 [25:21], rs2/rd [20:16], rd for register-register operations [15:11], function code [10:0], and a 16-bit immediate [15:0]. Opcodes: 0x00 register-register, 0x04 branch-if-zero, 0x05 branch-if-not-zero, 0x08 add-immediate, 0x0C and-immediate, 0x0D or-immediate, 0x0E xor-immediate, 0x23 load word, 0x2B store word.
- R4: Register-register function codes: 0x020 add, 0x022 subtract, 0x024 and, 0x025 or, 0x026 xor, 0x02A signed set-less-than, 0x004 shift left logical, 0x006 shift right logical. Shift operations use the low 5 bits of rs2. The result is written to the register in bits [15:11].
- R5: Immediate operations combine rs1 with the 16-bit immediate sign-extended to 32 bits. This applies to the logic operations as well. The result is written to the register in bits [20:16].
- R6: A load reads data memory at rs1 plus the sign-extended immediate. The returned word is written to the register in bits [20:16] during write-back.
- R7: A store writes the register in bits [20:16] to address rs1 plus the sign-extended immediate. The write strobe is high for exactly one cycle, in the memory step. No register is written, and the instruction takes 4 cycles.
- R8: A branch-if-zero is taken when rs1 equals 0, and a branch-if-not-zero is taken when rs1 is non-zero. A taken branch continues at (PC+4) plus the sign-extended immediate; a branch not taken continues at PC+4. A branch takes 4 cycles.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: An unsupported opcode, or a register-register word with an unsupported function code, changes no register and no memory location. It takes 4 cycles and continues at PC+4.
- R11: The retire strobe is high for exactly one cycle, in the last step of each instruction. Register-register operations, immediate operations and loads take 5 cycles.
- R12: Every instruction other than a taken branch is followed by a fetch at PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Instruction byte address (program counter) |
| imem_en | output | 1 | Instruction read request, high in fetch |
| imem_rdata | input | 32 | Instruction word, valid the cycle after the request |
| dmem_addr | output | 32 | Data byte address |
| dmem_re | output | 1 | Data read request (load, memory step) |
| dmem_we | output | 1 | Data write strobe (store, memory step) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, valid the cycle after the request |
| dbg_step | output | 3 | Current step, 0 fetch to 4 write-back |
| dbg_retire | output | 1 | One-cycle pulse when an instruction completes |

## Verification
Register contents cannot be seen at the ports, so the program copies every computed value to data memory with stores, and the store strobes expose what each instruction class wrote. The hardest case to reach is a write that must not happen: a write to register 0, an unsupported function code that carries a destination field, and an instruction skipped by a taken branch. Each of these targets a register that is later stored. A counted backward loop exercises both branch outcomes against the same condition register. An instruction-set model in the bench predicts every fetch address, every store and every instruction latency.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  localparam int INSN_W = 32;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    CL_NOP, CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH
  } class_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_e;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_BNEZ = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [10:0] FN_ADD = 11'h020;
  localparam logic [10:0] FN_SUB = 11'h022;
  localparam logic [10:0] FN_AND = 11'h024;
  localparam logic [10:0] FN_OR  = 11'h025;
  localparam logic [10:0] FN_XOR = 11'h026;
  localparam logic [10:0] FN_SLT = 11'h02A;
  localparam logic [10:0] FN_SLL = 11'h004;
  localparam logic [10:0] FN_SRL = 11'h006;

  typedef struct packed {
    class_e      cls;
    alu_e        op;
    logic        bnez;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [4:0]  rd;
    logic [15:0] imm16;
  } dec_t;

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
  import mcr_pkg::*;
(
  input  logic [INSN_W-1:0] iword,
  output dec_t              dec
);
  logic [5:0]  opc;
  logic [10:0] fn;

  assign opc = iword[31:26];
  assign fn  = iword[10:0];

  always_comb begin
    dec.rs1   = iword[25:21];
    dec.rs2   = iword[20:16];
    dec.rd    = iword[15:11];
    dec.imm16 = iword[15:0];
    dec.bnez  = 1'b0;
    dec.op    = ALU_ADD;
    dec.cls   = CL_NOP;
    case (opc)
      OPC_RR: begin
        dec.cls = CL_RR;
        case (fn)
          FN_ADD:  dec.op = ALU_ADD;
          FN_SUB:  dec.op = ALU_SUB;
          FN_AND:  dec.op = ALU_AND;
          FN_OR:   dec.op = ALU_OR;
          FN_XOR:  dec.op = ALU_XOR;
          FN_SLT:  dec.op = ALU_SLT;
          FN_SLL:  dec.op = ALU_SLL;
          FN_SRL:  dec.op = ALU_SRL;
          default: dec.cls = CL_NOP;
        endcase
      end
      OPC_ADDI: begin dec.cls = CL_RI; dec.op = ALU_ADD; end
      OPC_ANDI: begin dec.cls = CL_RI; dec.op = ALU_AND; end
      OPC_ORI:  begin dec.cls = CL_RI; dec.op = ALU_OR;  end
      OPC_XORI: begin dec.cls = CL_RI; dec.op = ALU_XOR; end
      OPC_LW:   dec.cls = CL_LOAD;
      OPC_SW:   dec.cls = CL_STORE;
      OPC_BEQZ: dec.cls = CL_BRANCH;
      OPC_BNEZ: begin dec.cls = CL_BRANCH; dec.bnez = 1'b1; end
      default:  dec.cls = CL_NOP;
    endcase
  end
endmodule

// File: rtl/mcr_regfile.sv
module mcr_regfile #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  localparam int RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   ra1,
  input  logic [RA_W-1:0]   ra2,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  input  logic              we,
  input  logic [RA_W-1:0]   wa,
  input  logic [DATA_W-1:0] wd
);
  logic [DATA_W-1:0] regs [1:NUM_REGS-1];

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          regs[g] <= '0;
      else if (we && (wa == RA_W'(g)))     regs[g] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mcr_alu.sv
module mcr_alu
  import mcr_pkg::*;
#(
  parameter int DATA_W  = 32,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  alu_e              op,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      ALU_ADD: res = x + y;
      ALU_SUB: res = x - y;
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      ALU_XOR: res = x ^ y;
      ALU_SLT: res = {{(DATA_W-1){1'b0}}, ($signed(x) < $signed(y))};
      ALU_SLL: res = x << y[SH_W-1:0];
      ALU_SRL: res = x >> y[SH_W-1:0];
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mcr_control.sv
module mcr_control
  import mcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  class_e cls,
  output step_e  step,
  output logic   retire
);
  logic needs_wb;
  assign needs_wb = (cls == CL_RR) || (cls == CL_RI) || (cls == CL_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) step <= ST_FETCH;
    else begin
      case (step)
        ST_FETCH:  step <= ST_DECODE;
        ST_DECODE: step <= ST_EXEC;
        ST_EXEC:   step <= ST_MEM;
        ST_MEM:    step <= needs_wb ? ST_WB : ST_FETCH;
        default:   step <= ST_FETCH;
      endcase
    end
  end

  assign retire = (step == ST_WB) || ((step == ST_MEM) && !needs_wb);
endmodule

// File: rtl/mc_risc_core.sv
module mc_risc_core
  import mcr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] imem_addr,
  output logic              imem_en,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic              dmem_re,
  output logic              dmem_we,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic [2:0]        dbg_step,
  output logic              dbg_retire
);
  localparam int RA_W = $clog2(NUM_REGS);
  localparam logic [DATA_W-1:0] WORD_BYTES = DATA_W'(DATA_W / 8);

  step_e step;
  dec_t  dec;
  logic  [INSN_W-1:0] iword;

  logic [DATA_W-1:0] pc, npc, a_q, b_q, imm_q, alu_out, rf_rd1, rf_rd2;
  logic [DATA_W-1:0] imm_ext, alu_x, alu_y, alu_res, rf_wd;
  logic [INSN_W-1:0] ir;
  logic              cond_q, rf_we;
  logic [RA_W-1:0]   rf_wa;

  // The instruction word is decoded straight from the memory port while
  // decode runs, and from the instruction register in every later step.
  assign iword = (step == ST_DECODE) ? imem_rdata : ir;

  mcr_decode u_dec (.iword(iword), .dec(dec));

  mcr_control u_ctl (
    .clk(clk), .rst_n(rst_n), .cls(dec.cls), .step(step), .retire(dbg_retire)
  );

  mcr_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(dec.rs1[RA_W-1:0]), .ra2(dec.rs2[RA_W-1:0]),
    .rd1(rf_rd1), .rd2(rf_rd2),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  assign imm_ext = {{(DATA_W-16){dec.imm16[15]}}, dec.imm16};
  assign alu_x   = (dec.cls == CL_BRANCH) ? npc : a_q;
  assign alu_y   = (dec.cls == CL_RR) ? b_q : imm_q;

  mcr_alu #(.DATA_W(DATA_W)) u_alu (
    .op(dec.op), .x(alu_x), .y(alu_y), .res(alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= RESET_PC;
      npc     <= RESET_PC;
      ir      <= '0;
      a_q     <= '0;
      b_q     <= '0;
      imm_q   <= '0;
      alu_out <= '0;
      cond_q  <= 1'b0;
    end else begin
      case (step)
        ST_FETCH: npc <= pc + WORD_BYTES;
        ST_DECODE: begin
          ir    <= imem_rdata;
          a_q   <= rf_rd1;
          b_q   <= rf_rd2;
          imm_q <= imm_ext;
        end
        ST_EXEC: begin
          alu_out <= alu_res;
          cond_q  <= (dec.cls == CL_BRANCH) && (dec.bnez ? (|a_q) : ~(|a_q));
        end
        ST_MEM: pc <= cond_q ? alu_out : npc;
        default: ;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign imem_en    = (step == ST_FETCH);
  assign dmem_addr  = alu_out;
  assign dmem_wdata = b_q;
  assign dmem_we    = (step == ST_MEM) && (dec.cls == CL_STORE);
  assign dmem_re    = (step == ST_MEM) && (dec.cls == CL_LOAD);

  // The data port's output register holds the loaded word during write-back.
  assign rf_we = (step == ST_WB);
  assign rf_wa = (dec.cls == CL_RR) ? dec.rd[RA_W-1:0] : dec.rs2[RA_W-1:0];
  assign rf_wd = (dec.cls == CL_LOAD) ? dmem_rdata : alu_out;

  assign dbg_step = step;
endmodule

// File: rtl/mc_risc_core_chk.sv
module mc_risc_core_chk
  import mcr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] imem_addr,
  input logic              dmem_we,
  input logic              dmem_re,
  input logic [2:0]        dbg_step,
  input logic              dbg_retire
);
  p_reset_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_step == ST_FETCH) && (imem_addr == RESET_PC));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step == ST_FETCH) |=> (dbg_step == ST_DECODE));

  p_decode_to_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step == ST_DECODE) |=> (dbg_step == ST_EXEC));

  p_exec_to_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step == ST_EXEC) |=> (dbg_step == ST_MEM));

  p_pc_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step != ST_MEM) |=> $stable(imem_addr));

  p_load_then_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> (dbg_step == ST_WB));

  p_store_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> dbg_retire && (dbg_step == ST_MEM));

  p_store_next_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> (imem_addr == $past(imem_addr) + DATA_W'(4)));

  p_retire_then_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_retire |=> (dbg_step == ST_FETCH));

  p_wb_retires_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_step == ST_WB) |-> dbg_retire && ($past(dbg_step) == ST_MEM));
endmodule

bind mc_risc_core mc_risc_core_chk #(.DATA_W(DATA_W), .RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .dmem_we(dmem_we),
  .dmem_re(dmem_re), .dbg_step(dbg_step), .dbg_retire(dbg_retire)
);

// File: tb/sim_mc_risc_core.sv
module sim_mc_risc_core;
  localparam int N_INSN = 52;
  localparam logic [31:0] RST_PC = 32'h0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic imem_en, dmem_re, dmem_we, dbg_retire;
  logic [2:0] dbg_step;

  always #5 clk = ~clk;

  mc_risc_core #(.RESET_PC(RST_PC)) u0 (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_en(imem_en),
    .imem_rdata(imem_rdata), .dmem_addr(dmem_addr), .dmem_re(dmem_re),
    .dmem_we(dmem_we), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dbg_step(dbg_step), .dbg_retire(dbg_retire)
  );

  logic [31:0] prog [256];
  logic [31:0] dram [64];

  always @(posedge clk) begin
    if (imem_en) imem_rdata <= prog[imem_addr[9:2]];
    if (dmem_re) dmem_rdata <= dram[dmem_addr[7:2]];
    if (dmem_we) dram[dmem_addr[7:2]] <= dmem_wdata;
  end

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Encoders (R3 field layout)
  function automatic logic [31:0] e_rr(input int rs1, input int rs2, input int rd,
                                       input logic [10:0] fn);
    return {6'h00, 5'(rs1), 5'(rs2), 5'(rd), fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] op, input int rs1, input int rt,
                                      input int imm);
    return {op, 5'(rs1), 5'(rt), 16'(imm)};
  endfunction

  // Scoreboard queues
  logic [31:0] q_fetch[$];
  string       q_fetch_tag[$];
  logic [63:0] q_store[$];
  string       q_store_tag[$];
  int          q_lat[$];
  string       q_lat_tag[$];

  task automatic load_program();
    int i = 0;
    int src [12] = '{3, 4, 5, 6, 7, 8, 9, 13, 14, 15, 16, 0};
    for (int k = 0; k < 256; k++) prog[k] = 32'hFC00_0000;
    for (int k = 0; k < 64; k++) dram[k] = 32'h0;
    prog[i++] = e_i(6'h08, 0, 1, 5);
    prog[i++] = e_i(6'h08, 0, 2, -3);
    prog[i++] = e_rr(1, 2, 3, 11'h020);
    prog[i++] = e_rr(1, 2, 4, 11'h022);
    prog[i++] = e_rr(1, 2, 5, 11'h024);
    prog[i++] = e_rr(1, 2, 6, 11'h025);
    prog[i++] = e_rr(1, 2, 7, 11'h026);
    prog[i++] = e_rr(2, 1, 8, 11'h02A);
    prog[i++] = e_rr(1, 8, 9, 11'h004);
    prog[i++] = e_rr(2, 8, 13, 11'h006);
    prog[i++] = e_i(6'h0C, 1, 14, 16'hFFFF);
    prog[i++] = e_i(6'h0D, 0, 15, 16'h8000);
    prog[i++] = e_i(6'h0E, 1, 16, 16'h00F0);
    prog[i++] = e_i(6'h08, 0, 0, 7);
    for (int k = 0; k < 12; k++) prog[i++] = e_i(6'h2B, 0, src[k], 4 * k);
    prog[i++] = e_i(6'h23, 0, 10, 4);
    prog[i++] = e_i(6'h2B, 0, 10, 48);
    prog[i++] = 32'hFC00_0000;
    prog[i++] = e_rr(1, 1, 11, 11'h3FF);
    prog[i++] = e_i(6'h04, 0, 0, 4);
    prog[i++] = e_i(6'h08, 0, 11, 99);
    prog[i++] = e_i(6'h05, 0, 0, 4);
    prog[i++] = e_i(6'h08, 0, 12, 3);
    prog[i++] = e_i(6'h08, 12, 12, -1);
    prog[i++] = e_i(6'h2B, 0, 12, 52);
    prog[i++] = e_i(6'h05, 12, 0, -12);
    prog[i++] = e_i(6'h2B, 0, 11, 56);
    prog[i++] = e_i(6'h08, 0, 18, 40);
    prog[i++] = e_i(6'h23, 18, 17, 8);
    prog[i++] = e_i(6'h2B, 18, 17, 20);
    prog[i++] = e_i(6'h04, 0, 0, -4);
  endtask

  // Instruction-set model built from the requirements; fills the scoreboard.
  task automatic build_expect();
    logic [31:0] r [32];
    string       rt_tag [32];
    logic [31:0] m [64];
    logic [31:0] pc = RST_PC;
    string       ftag = "R1";
    for (int k = 0; k < 32; k++) begin r[k] = 0; rt_tag[k] = "R9"; end
    for (int k = 0; k < 64; k++) m[k] = 0;
    for (int n = 0; n < N_INSN; n++) begin
      logic [31:0] w, a, b, simm, res, npc;
      int lat;
      string ltag;
      bit wr;
      int wreg;
      w = prog[pc[9:2]];
      a = r[w[25:21]]; b = r[w[20:16]];
      simm = {{16{w[15]}}, w[15:0]};
      npc = pc + 4;
      q_fetch.push_back(pc); q_fetch_tag.push_back({ftag, " R2"});
      ftag = "R12";
      lat = 4; ltag = "R10"; wr = 0; wreg = 0; res = 0;
      case (w[31:26])
        6'h00: begin
          wr = 1; wreg = w[15:11]; lat = 5; ltag = "R11 R4";
          case (w[10:0])
            11'h020: res = a + b;
            11'h022: res = a - b;
            11'h024: res = a & b;
            11'h025: res = a | b;
            11'h026: res = a ^ b;
            11'h02A: res = {31'b0, $signed(a) < $signed(b)};
            11'h004: res = a << b[4:0];
            11'h006: res = a >> b[4:0];
            default: begin wr = 0; lat = 4; ltag = "R10"; end
          endcase
        end
        6'h08, 6'h0C, 6'h0D, 6'h0E: begin
          wr = 1; wreg = w[20:16]; lat = 5; ltag = "R11 R5";
          case (w[31:26])
            6'h08: res = a + simm;
            6'h0C: res = a & simm;
            6'h0D: res = a | simm;
            default: res = a ^ simm;
          endcase
        end
        6'h23: begin
          wr = 1; wreg = w[20:16]; lat = 5; ltag = "R11 R6";
          res = m[(a + simm) >> 2];
        end
        6'h2B: begin
          ltag = "R7";
          q_store.push_back({a + simm, b});
          q_store_tag.push_back({"R3 R7 ", rt_tag[w[20:16]]});
          m[(a + simm) >> 2] = b;
        end
        6'h04, 6'h05: begin
          ltag = "R8";
          if ((w[26] && a != 0) || (!w[26] && a == 0)) npc = pc + 4 + simm;
          ftag = "R8";
        end
        default: ;
      endcase
      if (wr && wreg != 0) begin
        r[wreg] = res;
        rt_tag[wreg] = (w[31:26] == 6'h00) ? "R4" : (w[31:26] == 6'h23) ? "R6" : "R5";
      end
      if (w == e_rr(1, 1, 11, 11'h3FF)) rt_tag[11] = "R10 R8";
      q_lat.push_back(lat); q_lat_tag.push_back(ltag);
      pc = npc;
    end
  endtask

  int  retired = 0;
  int  cyc = 0;
  bit  run = 0;

  // Monitor: compares design activity against the scoreboard.
  always @(negedge clk) begin
    if (run && rst_n && retired < N_INSN) begin
      cyc++;
      if (imem_en) begin
        if (q_fetch.size() == 0) check(0, "R2", "unexpected fetch", imem_addr, 0);
        else begin
          logic [31:0] e; string t;
          e = q_fetch.pop_front(); t = q_fetch_tag.pop_front();
          check(imem_addr == e, t, "fetch address", imem_addr, e);
        end
      end
      if (dmem_we) begin
        if (q_store.size() == 0) check(0, "R7", "unexpected store", dmem_addr, 0);
        else begin
          logic [63:0] e; string t;
          e = q_store.pop_front(); t = q_store_tag.pop_front();
          check(dmem_addr == e[63:32], t, "store address", dmem_addr, e[63:32]);
          check(dmem_wdata == e[31:0], t, "store data", dmem_wdata, e[31:0]);
        end
      end
      if (dbg_retire) begin
        if (q_lat.size() == 0) check(0, "R11", "unexpected retire", 0, 0);
        else begin
          int e; string t;
          e = q_lat.pop_front(); t = q_lat_tag.pop_front();
          check(cyc == e, t, "instruction cycles", 32'(cyc), 32'(e));
        end
        cyc = 0;
        retired++;
      end
    end
  end

  initial begin
    load_program();
    build_expect();
    repeat (3) @(negedge clk);
    check(dbg_step == 3'd0, "R1", "step in reset", 32'(dbg_step), 0);
    check(imem_addr == RST_PC, "R1", "pc in reset", imem_addr, RST_PC);
    check(!dmem_we, "R1", "no write in reset", 32'(dmem_we), 0);
    check(!dbg_retire, "R1", "no retire in reset", 32'(dbg_retire), 0);
    run = 1;
    rst_n = 1'b1;
    for (int t = 0; t < 5000 && retired < N_INSN; t++) @(negedge clk);
    check(retired == N_INSN, "R11", "watchdog: retired count", 32'(retired), 32'(N_INSN));
    check(q_fetch.size() == 0, "R2", "fetches left", 32'(q_fetch.size()), 0);
    check(q_store.size() == 0, "R7", "stores left", 32'(q_store.size()), 0);
    check(q_lat.size() == 0, "R11", "retires left", 32'(q_lat.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule